// File: doc/BRIEF.md
# Sign-Driven Rotation Cell

This cell sits off the diagonal of a triangular QR array. It has no angle input. The boundary cell of its row pair has already resolved every rotation into a string of micro-rotation sign bits. This cell replays those sign bits on its own operands: one entry from the upper row and one from the lower row, each a complex value in signed fixed point with 10 fractional bits. The same cell serves channel-matrix entries and the extra column that holds the received vector.

An operation runs in two stages.

- **First stage.** Each complex entry is turned in its own plane by its own sign string, so the entry ends up aligned the same way as its row's pivot.
- **Second stage.** A real rotation between the two rows is applied twice with one shared sign string: once to the pair of real parts and once to the pair of imaginary parts.

Each stage runs eight micro-rotations, one per clock. Each stage ends with a gain fix that is a single arithmetic right shift. If the boundary cell asks for a pre-rotation, both entries are negated on entry.

The controller is a state machine with these states:

- `ST_IDLE` waits for `start`.
- `ST_ROT1` runs the first-stage micro-rotations.
- `ST_XPOSE` halves the lane contents and regroups them from per-entry lanes into per-component lanes.
- `ST_ROT2` runs the second-stage micro-rotations.
- `ST_SCALE` applies the final halving.
- `ST_DONE` presents the result for one cycle.

The transitions are:

- IDLE→ROT1 on `start`.
- ROT1→XPOSE after the last iteration.
- XPOSE→ROT2 unconditionally.
- ROT2→SCALE after the last iteration.
- SCALE→DONE unconditionally.
- DONE→IDLE unconditionally.

Top module: `sdr_cell`

## Requirements
- R1: After reset, `busy` and `done` are 0 and all four result ports are 0.
- R2: A `start` sampled high in `ST_IDLE` begins an operation. `busy` is 1 from the edge that samples `start` until `done` has been shown. `done` is a one-cycle pulse that rises on the 18th rising edge after the sampling edge, and `busy` falls on the next edge.
- R3: In the first stage each entry (x = real, y = imaginary) goes through 8 micro-rotations, i = 0..7. Iteration i computes x' = x − d·(y>>>i) and y' = y + d·(x>>>i). Here d = +1 when bit i of the entry's direction vector is 1 and −1 when it is 0. The upper entry uses `dir_u` and the lower entry uses `dir_l`.
- R4: After each stage every value is arithmetically shifted right by one bit, rounding toward minus infinity, as the gain fix.
- R5: In the second stage the same iteration rule is used with x = upper-row value and y = lower-row value. It is applied to the real pair and, separately, to the imaginary pair, both with `dir_r`.
- R6: When `neg` is 1 at start, both complex entries are negated before the first stage.
- R7: Operands, `neg` and the three direction vectors are captured at the start edge. Changes to them during an operation do not alter its result.
- R8: A `start` that arrives while `busy` is 1 is ignored. The result and the `done` timing of the running operation are unchanged.
- R9: While idle and without `start`, the result ports hold the last result and `done` stays 0.
- R10: Results are W+2 bits wide and never wrap, even for full-scale inputs of −2^(W−1) with negation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| neg | input | 1 | Pre-rotation: negate both entries on entry |
| ua_re | input | W | Upper-row entry, real part |
| ua_im | input | W | Upper-row entry, imaginary part |
| lb_re | input | W | Lower-row entry, real part |
| lb_im | input | W | Lower-row entry, imaginary part |
| dir_u | input | ITER | First-stage sign bits for the upper entry |
| dir_l | input | ITER | First-stage sign bits for the lower entry |
| dir_r | input | ITER | Second-stage sign bits shared by real and imaginary pairs |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| ou_re | output | W+2 | Rotated upper-row value, real part |
| ou_im | output | W+2 | Rotated upper-row value, imaginary part |
| ol_re | output | W+2 | Rotated lower-row value, real part |
| ol_im | output | W+2 | Rotated lower-row value, imaginary part |

## Verification
Every result is due at a fixed count of edges after the edge that samples `start`:

- `busy` is high one cycle later.
- `done` and the four results are valid after the 18th edge.
- `busy` is low after the 19th edge.

The bench drives inputs on falling edges and counts falling edges from the start pulse. It expects `done` low at the 18th sample, high with the predicted results at the 19th, and `busy` low at the 20th, so any shift of a pipeline register shows up as a timing failure. Disturbances are placed in the middle of the first stage: a second start, or changed operands. Their expected effect is therefore none at all.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROT1,
        ST_XPOSE,
        ST_ROT2,
        ST_SCALE,
        ST_DONE
    } sdr_state_e;

endpackage

// File: rtl/sdr_step.sv
// One signed micro-rotation with a variable shift; purely combinational.
module sdr_step #(
    parameter int IW = 18,
    parameter int SW = 3
) (
    input  logic signed [IW-1:0] x_i,
    input  logic signed [IW-1:0] y_i,
    input  logic [SW-1:0]        sh_i,
    input  logic                 dir_i,
    output logic signed [IW-1:0] x_o,
    output logic signed [IW-1:0] y_o
);

    logic signed [IW-1:0] xs;
    logic signed [IW-1:0] ys;

    always_comb begin
        xs = x_i >>> sh_i;
        ys = y_i >>> sh_i;
        if (dir_i) begin
            x_o = x_i - ys;
            y_o = y_i + xs;
        end else begin
            x_o = x_i + ys;
            y_o = y_i - xs;
        end
    end

endmodule

// File: rtl/sdr_lane.sv
// One (x, y) register pair that is either loaded or stepped by one micro-rotation.
module sdr_lane #(
    parameter int IW = 18,
    parameter int SW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic signed [IW-1:0] ldx_i,
    input  logic signed [IW-1:0] ldy_i,
    input  logic                 step_i,
    input  logic                 dir_i,
    input  logic [SW-1:0]        sh_i,
    output logic signed [IW-1:0] x_o,
    output logic signed [IW-1:0] y_o
);

    logic signed [IW-1:0] x_q;
    logic signed [IW-1:0] y_q;
    logic signed [IW-1:0] x_nx;
    logic signed [IW-1:0] y_nx;

    sdr_step #(.IW(IW), .SW(SW)) u_step (
        .x_i   (x_q),
        .y_i   (y_q),
        .sh_i  (sh_i),
        .dir_i (dir_i),
        .x_o   (x_nx),
        .y_o   (y_nx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
        end else if (load_i) begin
            x_q <= ldx_i;
            y_q <= ldy_i;
        end else if (step_i) begin
            x_q <= x_nx;
            y_q <= y_nx;
        end
    end

    assign x_o = x_q;
    assign y_o = y_q;

    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> ($stable(x_q) && $stable(y_q))); // R9

endmodule

// File: rtl/sdr_cell.sv
module sdr_cell
    import sdr_pkg::*;
#(
    parameter int W    = 16,
    parameter int ITER = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 neg,
    input  logic signed [W-1:0]  ua_re,
    input  logic signed [W-1:0]  ua_im,
    input  logic signed [W-1:0]  lb_re,
    input  logic signed [W-1:0]  lb_im,
    input  logic [ITER-1:0]      dir_u,
    input  logic [ITER-1:0]      dir_l,
    input  logic [ITER-1:0]      dir_r,
    output logic                 busy,
    output logic                 done,
    output logic signed [W+1:0]  ou_re,
    output logic signed [W+1:0]  ou_im,
    output logic signed [W+1:0]  ol_re,
    output logic signed [W+1:0]  ol_im
);

    localparam int IW = W + 2;
    localparam int SW = (ITER > 1) ? $clog2(ITER) : 1;
    localparam logic [SW-1:0] LAST = SW'(ITER - 1);

    sdr_state_e st_q;
    sdr_state_e st_d;
    logic [SW-1:0]   cnt_q;
    logic [SW-1:0]   cnt_d;
    logic [ITER-1:0] du_q;
    logic [ITER-1:0] dl_q;
    logic [ITER-1:0] dr_q;

    logic                 ln_load [2];
    logic                 ln_step [2];
    logic                 ln_dir  [2];
    logic signed [IW-1:0] ln_ldx  [2];
    logic signed [IW-1:0] ln_ldy  [2];
    logic signed [IW-1:0] ln_x    [2];
    logic signed [IW-1:0] ln_y    [2];

    function automatic logic signed [IW-1:0] prep(input logic signed [W-1:0] v,
                                                  input logic n);
        logic signed [IW-1:0] e;
        e = IW'(v);
        return n ? -e : e;
    endfunction

    // State, iteration count and captured sign strings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            du_q  <= '0;
            dl_q  <= '0;
            dr_q  <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (st_q == ST_IDLE && start) begin
                du_q <= dir_u;
                dl_q <= dir_l;
                dr_q <= dir_r;
            end
        end
    end

    // Next state
    always_comb begin
        st_d  = st_q;
        cnt_d = '0;
        unique case (st_q)
            ST_IDLE:  if (start) st_d = ST_ROT1;
            ST_ROT1: begin
                if (cnt_q == LAST) st_d = ST_XPOSE;
                else               cnt_d = cnt_q + 1'b1;
            end
            ST_XPOSE: st_d = ST_ROT2;
            ST_ROT2: begin
                if (cnt_q == LAST) st_d = ST_SCALE;
                else               cnt_d = cnt_q + 1'b1;
            end
            ST_SCALE: st_d = ST_DONE;
            ST_DONE:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // Outputs and lane control
    always_comb begin
        busy = (st_q != ST_IDLE);
        done = (st_q == ST_DONE);
        for (int k = 0; k < 2; k++) begin
            ln_load[k] = 1'b0;
            ln_step[k] = 1'b0;
            ln_dir[k]  = 1'b0;
            ln_ldx[k]  = '0;
            ln_ldy[k]  = '0;
        end
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    ln_load[0] = 1'b1;
                    ln_load[1] = 1'b1;
                    ln_ldx[0]  = prep(ua_re, neg);
                    ln_ldy[0]  = prep(ua_im, neg);
                    ln_ldx[1]  = prep(lb_re, neg);
                    ln_ldy[1]  = prep(lb_im, neg);
                end
            end
            ST_ROT1: begin
                ln_step[0] = 1'b1;
                ln_step[1] = 1'b1;
                ln_dir[0]  = du_q[cnt_q];
                ln_dir[1]  = dl_q[cnt_q];
            end
            ST_XPOSE: begin
                ln_load[0] = 1'b1;
                ln_load[1] = 1'b1;
                ln_ldx[0]  = ln_x[0] >>> 1;
                ln_ldy[0]  = ln_x[1] >>> 1;
                ln_ldx[1]  = ln_y[0] >>> 1;
                ln_ldy[1]  = ln_y[1] >>> 1;
            end
            ST_ROT2: begin
                ln_step[0] = 1'b1;
                ln_step[1] = 1'b1;
                ln_dir[0]  = dr_q[cnt_q];
                ln_dir[1]  = dr_q[cnt_q];
            end
            ST_SCALE: begin
                ln_load[0] = 1'b1;
                ln_load[1] = 1'b1;
                ln_ldx[0]  = ln_x[0] >>> 1;
                ln_ldy[0]  = ln_y[0] >>> 1;
                ln_ldx[1]  = ln_x[1] >>> 1;
                ln_ldy[1]  = ln_y[1] >>> 1;
            end
            ST_DONE: ;
            default: ;
        endcase
    end

    for (genvar g = 0; g < 2; g++) begin : g_lane
        sdr_lane #(.IW(IW), .SW(SW)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (ln_load[g]),
            .ldx_i  (ln_ldx[g]),
            .ldy_i  (ln_ldy[g]),
            .step_i (ln_step[g]),
            .dir_i  (ln_dir[g]),
            .sh_i   (cnt_q),
            .x_o    (ln_x[g]),
            .y_o    (ln_y[g])
        );
    end

    assign ou_re = ln_x[0];
    assign ol_re = ln_y[0];
    assign ou_im = ln_x[1];
    assign ol_im = ln_y[1];

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R2
    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R8
    AST_DIRS_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(du_q) && $stable(dl_q) && $stable(dr_q))); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(ou_re) && $stable(ou_im)
                               && $stable(ol_re) && $stable(ol_im))); // R9

endmodule

// File: tb/sdr_cell_bench.sv
`timescale 1ns/1ps
module sdr_cell_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic neg_s = 1'b0;
    logic signed [15:0] ur = '0, ui = '0, lr = '0, li = '0;
    logic [7:0] du = '0, dl = '0, dr = '0;
    logic busy, done;
    logic signed [17:0] ou_re, ou_im, ol_re, ol_im;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sdr_cell u_sdr_cell (
        .clk(clk), .rst_n(rst_n), .start(start), .neg(neg_s),
        .ua_re(ur), .ua_im(ui), .lb_re(lr), .lb_im(li),
        .dir_u(du), .dir_l(dl), .dir_r(dr),
        .busy(busy), .done(done),
        .ou_re(ou_re), .ou_im(ou_im), .ol_re(ol_re), .ol_im(ol_im)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic rot(inout int x, inout int y, input logic [7:0] d);
        for (int i = 0; i < 8; i++) begin
            int xs;
            int ys;
            xs = x >>> i;
            ys = y >>> i;
            if (d[i]) begin
                x = x - ys;
                y = y + xs;
            end else begin
                x = x + ys;
                y = y - xs;
            end
        end
    endtask

    task automatic model(input int a, b, c, e, input bit n,
                         input logic [7:0] pu, pl, pr,
                         output int o_ur, o_ui, o_lr, o_li);
        if (n) begin
            a = -a; b = -b; c = -c; e = -e;
        end
        rot(a, b, pu);              // upper entry, plane rotation
        rot(c, e, pl);              // lower entry, plane rotation
        a = a >>> 1; b = b >>> 1; c = c >>> 1; e = e >>> 1;
        rot(a, c, pr);              // real pair
        rot(b, e, pr);              // imaginary pair
        o_ur = a >>> 1; o_ui = b >>> 1; o_lr = c >>> 1; o_li = e >>> 1;
    endtask

    // mode: 0 plain, 1 extra start while busy, 2 operand change while busy
    task automatic do_op(input int a, b, c, e, input bit n,
                         input logic [7:0] pu, pl, pr, input int mode,
                         input string req);
        int x_ur, x_ui, x_lr, x_li;
        model(a, b, c, e, n, pu, pl, pr, x_ur, x_ui, x_lr, x_li);
        @(negedge clk);
        ur = 16'(a); ui = 16'(b); lr = 16'(c); li = 16'(e);
        neg_s = n; du = pu; dl = pl; dr = pr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R2", "busy after start", int'(busy), 1);
        for (int k = 2; k <= 20; k++) begin
            if (k == 4 && mode != 0) begin
                ur = ~ur; ui = 16'sd1234; lr = -lr; li = 16'sd77;
                neg_s = ~neg_s; du = ~du; dl = ~dl; dr = ~dr;
                if (mode == 1) start = 1'b1;
            end
            if (k == 5) start = 1'b0;
            @(negedge clk);
            if (k == 18) chk(done === 1'b0, req, "done early", int'(done), 0);
            if (k == 19) begin
                chk(done === 1'b1, req, "done due", int'(done), 1);
                chk(int'(ou_re) == x_ur, req, "upper re", int'(ou_re), x_ur);
                chk(int'(ou_im) == x_ui, req, "upper im", int'(ou_im), x_ui);
                chk(int'(ol_re) == x_lr, req, "lower re", int'(ol_re), x_lr);
                chk(int'(ol_im) == x_li, req, "lower im", int'(ol_im), x_li);
            end
            if (k == 20) begin
                chk(done === 1'b0, "R2", "done one cycle", int'(done), 0);
                chk(busy === 1'b0, "R2", "busy released", int'(busy), 0);
            end
        end
    endtask

    task automatic hold_test();
        int h0, h1, h2, h3;
        h0 = int'(ou_re); h1 = int'(ou_im); h2 = int'(ol_re); h3 = int'(ol_im);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            ur = 16'(k * 999); li = -16'(k * 37); du = 8'(k); dr = ~dr; neg_s = ~neg_s;
        end
        @(negedge clk);
        chk(done === 1'b0, "R9", "no done while idle", int'(done), 0);
        chk(int'(ou_re) == h0, "R9", "hold upper re", int'(ou_re), h0);
        chk(int'(ou_im) == h1, "R9", "hold upper im", int'(ou_im), h1);
        chk(int'(ol_re) == h2, "R9", "hold lower re", int'(ol_re), h2);
        chk(int'(ol_im) == h3, "R9", "hold lower im", int'(ol_im), h3);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy === 1'b0, "R1", "busy in reset", int'(busy), 0);
        chk(done === 1'b0, "R1", "done in reset", int'(done), 0);
        chk(ou_re == 0 && ou_im == 0, "R1", "upper zero", int'(ou_re), 0);
        chk(ol_re == 0 && ol_im == 0, "R1", "lower zero", int'(ol_re), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0, "R1", "idle after reset", int'(busy), 0);

        do_op(1000, -600, 250, 700, 1'b0, 8'b1011_0010, 8'h5C, 8'hA7, 0, "R3");
        do_op(1024, 0, 0, 0, 1'b0, 8'h00, 8'h00, 8'h00, 0, "R4");
        do_op(-1, -1, 1, -1, 1'b0, 8'hFF, 8'h0F, 8'hF0, 0, "R4");
        do_op(300, -900, -1200, 450, 1'b0, 8'hFF, 8'h00, 8'h3C, 0, "R5");
        do_op(1000, -600, 250, 700, 1'b1, 8'b1011_0010, 8'h5C, 8'hA7, 0, "R6");
        do_op(-4321, 2100, 777, -3000, 1'b0, 8'h96, 8'h69, 8'h55, 2, "R7");
        do_op(5000, 5000, -5000, 2500, 1'b1, 8'hC3, 8'h3C, 8'h81, 1, "R8");
        hold_test();
        do_op(-32768, -32768, -32768, -32768, 1'b1, 8'hFF, 8'hFF, 8'hFF, 0, "R10");
        do_op(32767, 32767, -32768, 32767, 1'b0, 8'h00, 8'hFF, 8'h00, 0, "R10");
        finish_run();
    end

endmodule